// File: doc/BRIEF.md
# Key-Seeded Word Expander

This block turns one 128-bit seed key into a long stream of 32-bit words for a pixel-masking cipher. The first four words are the seed itself. Each later word is the previous word XOR the word four places back. Every fourth word is different: it takes the previous word, rotates it left by one byte, passes each byte through the forward substitution table and XORs the result with a word derived from the key. That word is one of four constants cut from the key, with each of its bytes passed through the inverse substitution table. Both tables are read at an index rotated by an amount the key decides. A rotation of zero gives the standard forward and inverse substitution tables of the usual 128-bit block cipher.

A one-cycle `start` pulse loads the key and a word count. The block then presents the words one at a time on a valid/ready handshake. The stream does not end after a fixed round count. The host sets the count from the image size: two 4-word round keys for every 16 eight-bit pixels, which is 8 × m·n / 16 words. After the last word is taken, `done` rises. A new `start` pulse restarts the stream from the first word at any time.

Top module: `keyed_word_expander`

## Requirements
- R1: During and after reset, `out_valid` and `done` are 0 until the first `start` pulse.
- R2: Words 0 to 3 are the key words. Key bits [127:96] form word 0, [95:64] word 1, [63:32] word 2 and [31:0] word 3. Inside a word, byte 0 is bits [31:24].
- R3: For an index i that is not a multiple of 4 and is at least 4, word i = word i-1 XOR word i-4.
- R4: For an index i that is a multiple of 4 and is at least 4, word i = F XOR G XOR word i-4. F applies the forward table to each byte of the previous word after a one-byte left rotation, so bytes [b0,b1,b2,b3] become [b1,b2,b3,b0] before lookup. G applies the inverse table to each byte of the selected constant.
- R5: The constant for word i is chosen by (i/4) mod 4. Value 0 selects key word 3, value 1 selects key word 1, value 2 selects key word 0 and value 3 selects key word 2.
- R6: A forward lookup of byte x returns the standard forward substitution of (x + s) mod 256, where s is the sum of the 16 key bytes mod 256. With an all-zero key, word 4 is 32'h31313131.
- R7: An inverse lookup of byte x returns the standard inverse substitution of (x + v) mod 256. Here v = (S × floor(S/16)) mod 256, and S is the full sum of the 16 key bytes.
- R8: A word is taken on a clock edge where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, the word and `out_valid` stay unchanged.
- R9: Exactly `word_count` words are delivered, in order. Once the last word is taken, `out_valid` falls and `done` rises. A count of 0 gives `done` in the cycle after `start`, with no words.
- R10: A `start` pulse, even in the middle of a stream, clears `done` and presents word 0 of the new key in the next cycle. `out_valid` is then 1 if the new count is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that loads the key and the count |
| key_in | input | 128 | Seed key, sampled on `start` |
| word_count | input | CNT_W | Number of words to produce, sampled on `start` |
| out_valid | output | 1 | A word is presented |
| out_ready | input | 1 | The consumer takes the presented word |
| out_word | output | 32 | Presented expanded word |
| done | output | 1 | All requested words have been taken |

## Verification
The hardest case to reach is a rotated table lookup. The rotation amounts depend on the key only through a byte sum and a product, so a plain key pattern leaves most rotation values untried. The stimulus mixes directed keys (all zeros, all ones) with seeded random keys, so that many forward and inverse rotations appear. Random counts up to 64 words cycle the constant selector through all four values several times. Random back-pressure and a restart in the middle of a stream exercise the hold and reload paths.

// File: rtl/kexp_pkg.sv
package kexp_pkg;

    typedef logic [7:0]  byte_t;
    typedef logic [31:0] word_t;

    function automatic byte_t rotl8(input byte_t x, input int n);
        return byte_t'((x << n) | (x >> (8 - n)));
    endfunction

    // multiplication in GF(2^8) with the 0x11b reduction polynomial
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t r;
        byte_t p;
        r = 8'h00;
        p = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) r = r ^ p;
            p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
        end
        return r;
    endfunction

    // x^254 by square and multiply; maps 0 to 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t r;
        byte_t p;
        r = 8'h01;
        p = a;
        for (int k = 0; k < 8; k++) begin
            if (k != 0) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic byte_t fwd_sub(input byte_t x);
        byte_t b;
        b = gf_inv(x);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic byte_t inv_sub(input byte_t x);
        byte_t b;
        b = rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05;
        return gf_inv(b);
    endfunction

endpackage

// File: rtl/kexp_offsets.sv
module kexp_offsets
    import kexp_pkg::*;
(
    input  logic [127:0] key,
    output byte_t        fwd_off,
    output byte_t        inv_off
);
    localparam int NBYTES = 16;

    logic [11:0] sum;
    logic [7:0]  mean;
    logic [19:0] prod;

    always_comb begin
        sum = 12'd0;
        for (int b = 0; b < NBYTES; b++) begin
            sum = sum + {4'd0, key[8*b +: 8]};
        end
        mean    = sum[11:4];
        prod    = 20'(sum) * 20'(mean);
        fwd_off = sum[7:0];
        inv_off = prod[7:0];
    end
endmodule

// File: rtl/kexp_subword.sv
module kexp_subword
    import kexp_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  word_t din,
    input  byte_t offset,
    output word_t dout
);
    localparam int LANES = 4;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        byte_t idx;
        assign idx = din[8*g +: 8] + offset;
        if (INVERSE) begin : g_inv
            assign dout[8*g +: 8] = inv_sub(idx);
        end else begin : g_fwd
            assign dout[8*g +: 8] = fwd_sub(idx);
        end
    end
endmodule

// File: rtl/keyed_word_expander.sv
module keyed_word_expander
    import kexp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [127:0]     key_in,
    input  logic [CNT_W-1:0] word_count,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_word,
    output logic             done
);
    localparam int HIST = 3;

    typedef struct packed {
        logic [127:0]         key;
        byte_t                fwd_off;
        byte_t                inv_off;
        word_t [HIST-1:0]     hist;   // [0]=w[i-3] .. [2]=w[i-1]
        word_t                cur;    // w[i]
        logic [CNT_W-1:0]     idx;
        logic [CNT_W-1:0]     limit;
        logic                 valid;
        logic                 done;
    } st_t;

    st_t st_d, st_q;

    byte_t fwd_off_new, inv_off_new;
    word_t rot_w, rcon_w, fwd_w, inv_w, next_w;
    logic [CNT_W-1:0] nxt_idx;

    kexp_offsets u_offsets (
        .key     (key_in),
        .fwd_off (fwd_off_new),
        .inv_off (inv_off_new)
    );

    kexp_subword #(.INVERSE(1'b0)) u_fwd (
        .din    (rot_w),
        .offset (st_q.fwd_off),
        .dout   (fwd_w)
    );

    kexp_subword #(.INVERSE(1'b1)) u_inv (
        .din    (rcon_w),
        .offset (st_q.inv_off),
        .dout   (inv_w)
    );

    always_comb begin
        nxt_idx = st_q.idx + 1'b1;
        rot_w   = {st_q.cur[23:0], st_q.cur[31:24]};
        unique case (nxt_idx[3:2])
            2'd0:    rcon_w = st_q.key[31:0];
            2'd1:    rcon_w = st_q.key[95:64];
            2'd2:    rcon_w = st_q.key[127:96];
            default: rcon_w = st_q.key[63:32];
        endcase

        if (nxt_idx < CNT_W'(4)) begin
            unique case (nxt_idx[1:0])
                2'd1:    next_w = st_q.key[95:64];
                2'd2:    next_w = st_q.key[63:32];
                default: next_w = st_q.key[31:0];
            endcase
        end else if (nxt_idx[1:0] == 2'd0) begin
            next_w = fwd_w ^ inv_w ^ st_q.hist[0];
        end else begin
            next_w = st_q.cur ^ st_q.hist[0];
        end

        st_d = st_q;
        if (start) begin
            st_d.key     = key_in;
            st_d.fwd_off = fwd_off_new;
            st_d.inv_off = inv_off_new;
            st_d.hist    = '0;
            st_d.cur     = key_in[127:96];
            st_d.idx     = '0;
            st_d.limit   = word_count;
            st_d.valid   = (word_count != '0);
            st_d.done    = (word_count == '0);
        end else if (st_q.valid && out_ready) begin
            if (nxt_idx == st_q.limit) begin
                st_d.valid = 1'b0;
                st_d.done  = 1'b1;
            end else begin
                st_d.hist = {st_q.cur, st_q.hist[2], st_q.hist[1]};
                st_d.cur  = next_w;
                st_d.idx  = nxt_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.cur;
    assign done      = st_q.done;
endmodule

// File: rtl/kexp_checker.sv
module kexp_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [127:0]     key_in,
    input logic [CNT_W-1:0] word_count,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_word,
    input logic             done
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid && !done); // R1

    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> out_word == $past(key_in[127:96])); // R2

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !start |=> out_valid && $stable(out_word)); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid); // R9

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        start && word_count == '0 |=> done && !out_valid); // R9

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start && word_count != '0 |=> out_valid && !done); // R10
endmodule

bind keyed_word_expander kexp_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .key_in     (key_in),
    .word_count (word_count),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_word   (out_word),
    .done       (done)
);

// File: tb/keyed_word_expander_test.sv
module keyed_word_expander_test;
    localparam int CNT_W = 16;
    localparam int MAXW  = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [127:0]     key_in = '0;
    logic [CNT_W-1:0] word_count = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [31:0]      out_word;
    logic             done;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  t_fwd [256];
    logic [7:0]  t_inv [256];
    logic [31:0] exp_w [MAXW];

    always #4 clk = ~clk;

    keyed_word_expander #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
        .word_count(word_count), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] acc = 0;
        logic [15:0] wide = 0;
        for (int k = 0; k < 8; k++) if (b[k]) wide = wide ^ (16'(a) << k);
        for (int k = 15; k >= 8; k--) if (wide[k]) wide = wide ^ (16'h11b << (k - 8));
        acc = wide[8:0];
        return acc[7:0];
    endfunction

    function automatic logic [7:0] m_rot(input logic [7:0] x, input int n);
        return 8'((x << n) | (x >> (8 - n)));
    endfunction

    task automatic build_tables();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] iv = 0;
            logic [7:0] s;
            for (int y = 1; y < 256; y++) if (m_mul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
            s = iv ^ m_rot(iv,1) ^ m_rot(iv,2) ^ m_rot(iv,3) ^ m_rot(iv,4) ^ 8'h63;
            t_fwd[x] = s;
            t_inv[s] = 8'(x);
        end
    endtask

    task automatic model(input logic [127:0] k);
        logic [11:0] sum = 0;
        logic [7:0]  fo, io, mean;
        logic [31:0] rc [4];
        for (int b = 0; b < 16; b++) sum += 12'(k[8*b +: 8]);
        fo   = sum[7:0];
        mean = 8'(sum / 16);
        io   = 8'((32'(sum) * 32'(mean)) % 256);
        rc[0] = k[31:0]; rc[1] = k[95:64]; rc[2] = k[127:96]; rc[3] = k[63:32];
        for (int i = 0; i < MAXW; i++) begin
            if (i < 4) exp_w[i] = k[127 - 32*i -: 32];
            else if (i % 4 == 0) begin
                logic [31:0] p = exp_w[i-1];
                logic [31:0] c = rc[(i/4) % 4];
                logic [31:0] t;
                t = {t_fwd[8'(p[23:16] + fo)], t_fwd[8'(p[15:8] + fo)],
                     t_fwd[8'(p[7:0] + fo)],  t_fwd[8'(p[31:24] + fo)]};
                t ^= {t_inv[8'(c[31:24] + io)], t_inv[8'(c[23:16] + io)],
                      t_inv[8'(c[15:8] + io)],  t_inv[8'(c[7:0] + io)]};
                exp_w[i] = t ^ exp_w[i-4];
            end else exp_w[i] = exp_w[i-1] ^ exp_w[i-4];
        end
    endtask

    // stop_at < 0: run to done; otherwise return after stop_at words were taken
    task automatic run_stream(input logic [127:0] k, input int cnt, input int rdy_pct, input int stop_at);
        int n = 0;
        int guard = 0;
        bit took;
        model(k);
        @(negedge clk);
        start = 1'b1; key_in = k; word_count = CNT_W'(cnt); out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(out_word == exp_w[0], "R10 first word after start", out_word, exp_w[0]);
        check(done == (cnt == 0), "R10 done after start", 32'(done), 32'(cnt == 0));
        forever begin
            if (stop_at >= 0 && n == stop_at) return;
            if (done) break;
            if (guard++ > 4000) begin
                check(1'b0, "R9 stream hung", 32'(n), 32'(cnt));
                break;
            end
            if (out_valid) begin
                if (n < 4)            check(out_word == exp_w[n], "R2 key word", out_word, exp_w[n]);
                else if (n % 4 == 0)  check(out_word == exp_w[n], "R4 R5 R6 R7 keyed word", out_word, exp_w[n]);
                else                  check(out_word == exp_w[n], "R3 xor word", out_word, exp_w[n]);
            end
            out_ready = ($urandom % 100) < rdy_pct;
            took = out_valid && out_ready;
            @(negedge clk);
            if (took) n++;
        end
        out_ready = 1'b0;
        check(n == cnt, "R9 word total", 32'(n), 32'(cnt));
        check(!out_valid, "R9 valid low at done", 32'(out_valid), 0);
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1729));
        build_tables();
        repeat (3) @(negedge clk);
        check(!out_valid && !done, "R1 reset idle", {out_valid, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && !done, "R1 idle before start", {out_valid, done}, 0);

        // R6: all-zero key gives rotation 0, word 4 known constant
        model('0);
        check(exp_w[4] == 32'h31313131, "R6 bench model w4", exp_w[4], 32'h31313131);
        run_stream('0, 8, 100, -1);
        run_stream({16{8'hff}}, 24, 100, -1);
        run_stream(128'h000102030405060708090a0b0c0d0e0f, 20, 60, -1);
        // R9: zero count
        run_stream(128'h0123456789abcdef0123456789abcdef, 0, 100, -1);
        // R10: restart while words are still pending
        run_stream(128'hdeadbeef00112233445566778899aabb, 40, 70, 6);
        run_stream(128'h55aa55aa00ff00ff13579bdf2468ace0, 12, 100, -1);
        for (int r = 0; r < 8; r++) begin
            logic [127:0] k = {$urandom, $urandom, $urandom, $urandom};
            run_stream(k, 1 + int'($urandom % MAXW), 50, -1);
        end
        run_stream(128'hcafef00d_0badc0de_feedface_8badf00d, MAXW, 30, -1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule